// File: doc/BRIEF.md
# Multi-channel edge-programmed PWM generator

This block produces sixteen pulse-width-modulated outputs from one shared timebase. A prescaler divides the input clock, and a step counter advances once per prescaler wrap and returns to zero after a programmable last step. The programmed prescale and step limit both count one above their register value, so one full output period lasts (prescale_val+1)*(step_limit+1) input clocks.

Each channel has no duty or polarity field. Its waveform comes from two absolute step positions. When the step counter enters the rising position, the output goes high. When it enters the falling position, the output goes low. If both positions are equal, the output toggles once per period, which gives a half-duty wave at twice the period. A position beyond the last step never fires, so the output holds a constant level. Placing the falling position before the rising position gives an active-low window.

Configuration arrives as parallel register values that are held steady by the surrounding logic. Bus decoding and staged (shadow) updates are handled outside this block.

Top module: `pwm_edge_gen`

## Requirements
- R1: While rst_n is low, every pwm_out bit is 0 and both counters are cleared. After release, every output stays 0 until its first edge event.
- R2: The prescaler counts 0..prescale_val and wraps to 0. Each wrap advances the step counter by one, and the step counter goes from step_limit back to 0. An output period is therefore (prescale_val+1)*(step_limit+1) clocks. Step 0 is first entered at the first wrap of the step counter after reset.
- R3: An enabled channel goes high on the clock edge at which the step counter enters the step equal to its rising value. It goes low on the edge at which the counter enters the step equal to its falling value. Between step entries the output does not change.
- R4: If the rising and falling values of a channel are equal, the output inverts at each entry into that step. This gives a 50% wave whose period is twice the programmed period.
- R5: A rising or falling value greater than step_limit never fires. With step_limit at most 254, setting one edge to step_limit+1 yields a constant level: always high after the first rise, or never high.
- R6: A falling value below the rising value makes the high window wrap across step 0. The output is low from the falling step up to the step before the rising step, which makes the channel active-low.
- R7: A channel whose chan_en bit is 0 drives 0 from the next clock edge on, and its edge state is cleared. After the bit returns to 1, the output is evaluated again from the next step entry.
- R8: All channels use the single shared timebase, and each output is independent. The values for channel i are taken from bits [i*8 +: 8] of rise_pos and fall_pos, and from bit i of chan_en and pwm_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_val | input | 8 | Prescaler limit; the divider is this value plus one |
| step_limit | input | 8 | Last step index; the number of steps per period is this value plus one |
| chan_en | input | 16 | Per-channel enable |
| rise_pos | input | 128 | Rising-edge step position, 8 bits per channel |
| fall_pos | input | 128 | Falling-edge step position, 8 bits per channel |
| pwm_out | output | 16 | PWM outputs |

## Verification
A cycle-exact reference, derived from the period formula and the edge rules, predicts all sixteen outputs on every clock. It is tried with mixed rise/fall patterns, with a range of prescale and step-limit values up to the widest prescaler, and with coincident edges. It is also tried with edges placed past the last step, with swapped (active-low) edge orders, and with enable toggled mid-period.

Separate measurements of rising-to-rising distance and high time then tell several failures apart:
- a divider that is off by one;
- coincident edges handled as set-only or clear-only;
- a never-matching edge that fires anyway;
- an enable that does not clear the output.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

   // Action taken by a channel when the step counter enters a new step
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_FLIP = 2'd3
   } edge_act_e;

   function automatic edge_act_e decode_edges(input logic hit_rise, input logic hit_fall);
      edge_act_e act;
      unique case ({hit_rise, hit_fall})
         2'b10:   act = ACT_SET;
         2'b01:   act = ACT_CLR;
         2'b11:   act = ACT_FLIP;
         default: act = ACT_HOLD;
      endcase
      return act;
   endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
   parameter int  PW      = 8,
   parameter bit  ENABLED = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] limit,
   output logic          tick
);

   generate
      if (ENABLED) begin : g_div
         logic [PW-1:0] cnt;

         // Compare with >= so that a lowered limit still wraps
         assign tick = (cnt >= limit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (tick) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end

         // R2: a wrap tick is always followed by a cleared count
         p_tick_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> (cnt == '0));

         // R2: without a tick, the count advances by exactly one
         p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !tick |=> (cnt == $past(cnt) + 1'b1));
      end else begin : g_nodiv
         // Prescaler removed: the step counter advances on every clock
         assign tick = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter #(
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [SW-1:0] limit,
   output logic [SW-1:0] step,
   output logic [SW-1:0] step_next
);

   // The step that the next advance will enter
   assign step_next = (step >= limit) ? '0 : step + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   step <= '0;
      else if (adv) step <= step_next;
   end

   // R2: the step holds between advances
   p_step_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(step));

   // R2: an advance at the last step returns the counter to zero
   p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && (step >= limit)) |=> (step == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
   import pwm_edge_pkg::*;
#(
   parameter int SW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          en,
   input  logic [SW-1:0] step_next,
   input  logic [SW-1:0] rise_at,
   input  logic [SW-1:0] fall_at,
   output logic          out
);

   logic      hit_rise;
   logic      hit_fall;
   edge_act_e act;

   assign hit_rise = (step_next == rise_at);
   assign hit_fall = (step_next == fall_at);
   assign act      = decode_edges(hit_rise, hit_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       out <= 1'b0;
      else if (!en)     out <= 1'b0;
      else if (adv) begin
         unique case (act)
            ACT_SET:  out <= 1'b1;
            ACT_CLR:  out <= 1'b0;
            ACT_FLIP: out <= ~out;
            default:  out <= out;
         endcase
      end
   end

   // R7: a disabled channel is low one edge later
   p_disabled_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !out);

   // R3: the output only moves on a step entry
   p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv) |=> $stable(out));

   // R3: entering the rising step alone drives the output high
   p_rise_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && (step_next == rise_at) && (step_next != fall_at)) |=> out);

   // R3: entering the falling step alone drives the output low
   p_fall_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && (step_next == fall_at) && (step_next != rise_at)) |=> !out);

   // R4: coincident edges invert the output
   p_equal_flips_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && (step_next == rise_at) && (rise_at == fall_at)) |=> (out != $past(out)));

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
   parameter int NCH     = 16,
   parameter int PW      = 8,
   parameter int SW      = 8,
   parameter bit HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PW-1:0]     prescale_val,
   input  logic [SW-1:0]     step_limit,
   input  logic [NCH-1:0]    chan_en,
   input  logic [NCH*SW-1:0] rise_pos,
   input  logic [NCH*SW-1:0] fall_pos,
   output logic [NCH-1:0]    pwm_out
);

   localparam int BUSW = NCH * SW;

   generate
      if (NCH < 1 || NCH > 256) begin : g_bad_nch
         $error("pwm_edge_gen: NCH out of range");
      end
      if (PW < 1 || PW > 16) begin : g_bad_pw
         $error("pwm_edge_gen: PW out of range");
      end
      if (SW < 2 || SW > 16) begin : g_bad_sw
         $error("pwm_edge_gen: SW out of range");
      end
      if (BUSW != $bits(rise_pos)) begin : g_bad_bus
         $error("pwm_edge_gen: edge bus width mismatch");
      end
   endgenerate

   logic          tick;
   logic [SW-1:0] step_cur;
   logic [SW-1:0] step_nxt;

   pwm_prescaler #(.PW(PW), .ENABLED(HAS_DIV)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .limit (prescale_val),
      .tick  (tick)
   );

   pwm_step_counter #(.SW(SW)) u_steps (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (tick),
      .limit     (step_limit),
      .step      (step_cur),
      .step_next (step_nxt)
   );

   // R8: one channel per output, all on the shared timebase
   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         pwm_channel #(.SW(SW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .adv       (tick),
            .en        (chan_en[i]),
            .step_next (step_nxt),
            .rise_at   (rise_pos[i*SW +: SW]),
            .fall_at   (fall_pos[i*SW +: SW]),
            .out       (pwm_out[i])
         );
      end
   endgenerate

   // R2: the shared step never exceeds the limit while the limit is steady
   p_step_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(step_limit) && (step_cur <= step_limit)) |=> (step_cur <= step_limit));

   // R7: with every channel disabled, every output is low on the next edge
   p_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en == '0) |=> (pwm_out == '0));

endmodule

// File: tb/pwm_edge_gen_bench.sv
module pwm_edge_gen_bench;

   localparam int NCH = 16;
   localparam int SW  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [7:0]     presc = '0;
   logic [7:0]     slim = '0;
   logic [NCH-1:0] en = '0;
   logic [SW-1:0]  rise_a [NCH];
   logic [SW-1:0]  fall_a [NCH];
   logic [NCH*SW-1:0] rise_bus;
   logic [NCH*SW-1:0] fall_bus;
   logic [NCH-1:0] pwm;

   int    nvec  = 0;
   int    nfail = 0;
   string cur_req = "R1";

   logic [NCH-1:0] exp_q [$];
   logic [NCH-1:0] mdl;
   int             tcnt;

   always #10 clk = ~clk;   // 50 MHz

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         rise_bus[i*SW +: SW] = rise_a[i];
         fall_bus[i*SW +: SW] = fall_a[i];
      end
   end

   pwm_edge_gen u_pwm_edge_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .prescale_val (presc),
      .step_limit   (slim),
      .chan_en      (en),
      .rise_pos     (rise_bus),
      .fall_pos     (fall_bus),
      .pwm_out      (pwm)
   );

   // Reference: one step entry every (prescale+1) clocks, step index from the clock count
   always @(posedge clk) begin
      if (!rst_n) begin
         tcnt = 0;
         mdl  = '0;
      end else begin
         tcnt = tcnt + 1;
         for (int ch = 0; ch < NCH; ch++) begin
            if (!en[ch]) begin
               mdl[ch] = 1'b0;
            end else if (tcnt % (int'(presc) + 1) == 0) begin
               int  st;
               logic hr;
               logic hf;
               st = (tcnt / (int'(presc) + 1)) % (int'(slim) + 1);
               hr = (int'(rise_a[ch]) == st);
               hf = (int'(fall_a[ch]) == st);
               if (hr && hf)  mdl[ch] = ~mdl[ch];
               else if (hr)   mdl[ch] = 1'b1;
               else if (hf)   mdl[ch] = 1'b0;
            end
         end
         exp_q.push_back(mdl);
      end
   end

   // Monitor: pop and compare away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [NCH-1:0] e;
         e = exp_q.pop_front();
         nvec++;
         if (pwm !== e) begin
            nfail++;
            $display("FAIL %s scoreboard: pwm actual %h expected %h at %0t", cur_req, pwm, e, $time);
         end
      end
   end

   task automatic chk(input string req, input int act, input int expv, input string what);
      nvec++;
      if (act != expv) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic set_all(input int r, input int f);
      for (int i = 0; i < NCH; i++) begin
         rise_a[i] = SW'(r);
         fall_a[i] = SW'(f);
      end
   endtask

   // Hold reset with the new configuration, check reset state (R1), release
   task automatic start_case(input string req, input int p, input int s);
      @(negedge clk);
      #2;
      cur_req = req;
      rst_n = 1'b0;
      presc = 8'(p);
      slim  = 8'(s);
      @(negedge clk);
      chk("R1", int'(pwm), 0, "outputs during reset");
      @(negedge clk);
      #2;
      rst_n = 1'b1;
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   // Wait for a low-to-high change of one output, sampled at negedges
   task automatic wait_rise(input int ch);
      logic prev;
      prev = pwm[ch];
      for (int k = 0; k < 5000; k++) begin
         @(negedge clk);
         if (!prev && pwm[ch]) return;
         prev = pwm[ch];
      end
   endtask

   task automatic measure_period(input int ch, input int expv, input string req);
      int n;
      wait_rise(ch);
      n = 0;
      begin
         logic prev;
         prev = pwm[ch];
         for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            n++;
            if (!prev && pwm[ch]) break;
            prev = pwm[ch];
         end
      end
      chk(req, n, expv, $sformatf("rise-to-rise clocks ch%0d", ch));
   endtask

   task automatic high_count(input int ch, input int len, input int expv, input string req);
      int n;
      wait_rise(ch);
      n = 1;
      for (int k = 1; k < len; k++) begin
         @(negedge clk);
         if (pwm[ch]) n++;
      end
      chk(req, n, expv, $sformatf("high clocks per period ch%0d", ch));
   endtask

   task automatic count_high_window(input int ch, input int len, input int expv, input string req);
      int n;
      n = 0;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         if (pwm[ch]) n++;
      end
      chk(req, n, expv, $sformatf("high clocks in window ch%0d", ch));
   endtask

   initial begin
      set_all(0, 0);

      // R1 / R2 / R3: mixed positions, prescale 2, ten steps
      en = '1;
      for (int i = 0; i < NCH; i++) begin
         rise_a[i] = SW'((i * 3) % 10);
         fall_a[i] = SW'((i * 7 + 2) % 10);
      end
      rise_a[0] = 8'd0; fall_a[0] = 8'd4;
      start_case("R2", 2, 9);
      chk("R1", int'(pwm), 0, "outputs right after release");
      measure_period(0, 30, "R2");
      high_count(0, 30, 12, "R3");
      wait_n(60);

      // R2 at the widest prescaler, and the widest step counter
      set_all(0, 2);
      start_case("R2", 255, 3);
      measure_period(0, 1024, "R2");
      set_all(0, 200);
      start_case("R2", 1, 255);
      measure_period(0, 512, "R2");
      high_count(0, 512, 400, "R3");

      // R4: coincident edges toggle at twice the period
      set_all(1, 3);
      rise_a[1] = 8'd2; fall_a[1] = 8'd2;
      start_case("R4", 0, 4);
      measure_period(1, 10, "R4");
      high_count(1, 10, 5, "R4");
      wait_n(40);

      // R5: edges past the last step never fire
      set_all(2, 5);
      rise_a[0] = 8'd0; fall_a[0] = 8'd7;
      rise_a[1] = 8'd7; fall_a[1] = 8'd3;
      rise_a[3] = 8'd6; fall_a[3] = 8'd0;
      start_case("R5", 1, 6);
      wait_n(40);
      count_high_window(0, 28, 28, "R5");
      count_high_window(1, 28, 0, "R5");
      high_count(3, 14, 2, "R3");

      // R6: falling position below rising gives an active-low window
      set_all(0, 4);
      rise_a[2] = 8'd6; fall_a[2] = 8'd1;
      rise_a[3] = 8'd1; fall_a[3] = 8'd6;
      start_case("R6", 0, 7);
      high_count(2, 8, 3, "R6");
      high_count(3, 8, 5, "R6");
      wait_n(24);

      // R7: enable held low, raised mid-run, then dropped
      set_all(0, 2);
      en = 16'hFFFE;
      start_case("R7", 1, 3);
      count_high_window(0, 30, 0, "R7");
      #2 en[0] = 1'b1;
      measure_period(0, 8, "R7");
      wait_n(3);
      #2 en[0] = 1'b0;
      @(negedge clk);
      chk("R7", int'(pwm[0]), 0, "output one edge after disable");
      count_high_window(0, 16, 0, "R7");

      // R8: every channel on the shared timebase, staggered positions
      en = '1;
      for (int i = 0; i < NCH; i++) begin
         rise_a[i] = SW'(i);
         fall_a[i] = SW'((i + 8) % 16);
      end
      start_case("R8", 0, 15);
      measure_period(5, 16, "R8");
      measure_period(12, 16, "R8");
      high_count(9, 16, 8, "R8");
      wait_n(50);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   // Watchdog
   initial begin
      #(20 * 150000);
      nfail++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule